// File: doc/BRIEF.md
# Single-Shot Frame Grab Write Controller

This block drives the write side of an external frame-buffer FIFO from the timing outputs of an image sensor. It runs on the sensor pixel clock, which also clocks the FIFO write port and never stops. A host arms the block. On the next frame-boundary edge of vertical sync, the block resets the FIFO write pointer. It then opens the write strobe for the first active frame that follows, gated line by line by the horizontal reference. When that frame ends, the block freezes writing so that the FIFO holds one still picture. The freeze lasts until the host reports that it has finished reading.

Vertical sync, the arm request and the read-done acknowledge are brought into the pixel-clock domain through synchroniser chains and then edge-detected. A parameter selects the polarity of vertical sync, so the same edge logic serves sensors whose sync is high during blanking and sensors whose sync is low during blanking. The horizontal reference goes straight into the final NAND that forms the write strobe.

Top module: `frame_grab_wctl`

## Requirements
- R1: While the synchronous reset is high and after it is released, the block is idle: write-pointer reset `wrst_n` = 1, write enable `we_n` = 1 and `frame_held` = 0.
- R2: After arming, the next frame-boundary edge of vertical sync (the start of blanking) drives `wrst_n` low for exactly RST_CYCLES consecutive clocks, in a single pulse. RST_CYCLES is at least 2.
- R3: With VS_INVERT = 0, a high vertical sync marks blanking. With VS_INVERT = 1, a low vertical sync marks blanking. Two blocks fed with opposite sync levels under the matching setting produce identical outputs.
- R4: In the first active frame after the reset pulse, `we_n` is the NAND of the capture window and `href`. The number of low cycles of `we_n` equals the number of cycles on which `href` is high in that frame.
- R5: `we_n` stays high when the block is not armed, during the frame in which arming took place, and during the reset pulse.
- R6: `frame_held` rises at the frame-boundary edge that ends the captured frame. It stays high, with `we_n` high, over any later frames until a read-done rising edge arrives, and then falls.
- R7: An arm request received while a frame is held is ignored. After read-done, the following frames produce no reset pulse and no writes.
- R8: If the arm and read-done edges reach the block in the same cycle while a frame is held, the block returns to idle and discards the arm.
- R9: An arm request that arrives in the middle of an active frame waits for that frame's closing boundary edge to pulse the reset. The frame after that edge is the one captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sensor pixel clock, free-running; also the FIFO write clock |
| rst | input | 1 | Synchronous reset, active high |
| vsync | input | 1 | Sensor vertical sync, polarity set by VS_INVERT |
| href | input | 1 | Sensor horizontal reference, high on valid pixels |
| arm | input | 1 | Host request to capture one frame (rising edge) |
| rd_done | input | 1 | Host acknowledge that readout is finished (rising edge) |
| wrst_n | output | 1 | FIFO write-pointer reset, active low |
| we_n | output | 1 | FIFO write enable, active low |
| frame_held | output | 1 | A complete frame is held in the FIFO |

## Verification
Two host events can land in the same clock cycle: the read-done acknowledge that releases a held frame, and a fresh arm request. The bench drives both inputs on the same cycle, so their synchronised edges coincide while the block is holding a frame. It then checks that the flag drops and that the next two frames produce neither a reset pulse nor any writes, which shows that the arm was dropped. A second overlap occurs when an arm lands mid-frame. The bench verifies that the pulse waits for that frame's closing edge and that only the next frame is written. Line counts, line lengths and gaps are drawn at random from a fixed seed, and the expected write counts are computed from them.

// File: rtl/fgw_pkg.sv
package fgw_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ARMED,
      ST_PULSE,
      ST_WAITF,
      ST_WRITE,
      ST_HELD
   } fgw_state_e;
endpackage

// File: rtl/fgw_edge_sync.sv
module fgw_edge_sync #(
   parameter int STAGES = 2,
   parameter bit INVERT = 1'b0
) (
   input  logic clk,
   input  logic rst,
   input  logic din,
   output logic level,
   output logic rise,
   output logic fall
);
   localparam int TOP = STAGES - 1;

   if (STAGES < 2) begin : g_bad_stages
      $error("fgw_edge_sync: STAGES must be at least 2");
   end

   logic din_norm;
   if (INVERT) begin : g_inv
      assign din_norm = ~din;
   end else begin : g_pass
      assign din_norm = din;
   end

   logic [TOP:0] chain;
   logic         prev;

   always_ff @(posedge clk) begin
      if (rst) begin
         chain <= '0;
         prev  <= 1'b0;
      end else begin
         chain <= {chain[TOP-1:0], din_norm};
         prev  <= chain[TOP];
      end
   end

   assign level = chain[TOP];
   assign rise  = chain[TOP] & ~prev;
   assign fall  = ~chain[TOP] & prev;
endmodule

// File: rtl/fgw_sequencer.sv
module fgw_sequencer
   import fgw_pkg::*;
#(
   parameter int RST_CYCLES = 3
) (
   input  logic clk,
   input  logic rst,
   input  logic arm_rise,
   input  logic done_rise,
   input  logic vs_rise,
   input  logic vs_fall,
   output logic wrst_n,
   output logic cap_en,
   output logic held
);
   localparam int CW = $clog2(RST_CYCLES + 1);
   localparam logic [CW-1:0] LAST = CW'(RST_CYCLES - 1);

   if (RST_CYCLES < 2) begin : g_bad_rst
      $error("fgw_sequencer: RST_CYCLES must be at least 2");
   end

   fgw_state_e    state, state_nx;
   logic [CW-1:0] cnt;

   always_comb begin
      state_nx = state;
      unique case (state)
         ST_IDLE:  if (arm_rise)      state_nx = ST_ARMED;
         ST_ARMED: if (vs_rise)       state_nx = ST_PULSE;
         ST_PULSE: if (cnt == LAST)   state_nx = ST_WAITF;
         ST_WAITF: if (vs_fall)       state_nx = ST_WRITE;
         ST_WRITE: if (vs_rise)       state_nx = ST_HELD;
         ST_HELD:  if (done_rise)     state_nx = ST_IDLE;
         default:                     state_nx = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state <= ST_IDLE;
         cnt   <= '0;
      end else begin
         state <= state_nx;
         cnt   <= (state == ST_PULSE) ? cnt + 1'b1 : '0;
      end
   end

   assign wrst_n = (state != ST_PULSE);
   assign cap_en = (state == ST_WRITE);
   assign held   = (state == ST_HELD);

   AST_RST_MIN_WIDTH: assert property (@(posedge clk) disable iff (rst)
      $fell(wrst_n) |=> !wrst_n); // R2
   AST_HELD_UNTIL_DONE: assert property (@(posedge clk) disable iff (rst)
      held && !done_rise |=> held); // R6
   AST_HELD_NO_CAPTURE: assert property (@(posedge clk) disable iff (rst)
      held |-> !cap_en && wrst_n); // R7
endmodule

// File: rtl/frame_grab_wctl.sv
module frame_grab_wctl #(
   parameter int RST_CYCLES  = 3,
   parameter int SYNC_STAGES = 2,
   parameter bit VS_INVERT   = 1'b0
) (
   input  logic clk,
   input  logic rst,
   input  logic vsync,
   input  logic href,
   input  logic arm,
   input  logic rd_done,
   output logic wrst_n,
   output logic we_n,
   output logic frame_held
);
   logic vs_lvl, vs_rise, vs_fall;
   logic arm_lvl, arm_rise, arm_fall;
   logic done_lvl, done_rise, done_fall;
   logic cap_en;

   fgw_edge_sync #(.STAGES(SYNC_STAGES), .INVERT(VS_INVERT)) u_vs (
      .clk(clk), .rst(rst), .din(vsync),
      .level(vs_lvl), .rise(vs_rise), .fall(vs_fall));

   fgw_edge_sync #(.STAGES(SYNC_STAGES), .INVERT(1'b0)) u_arm (
      .clk(clk), .rst(rst), .din(arm),
      .level(arm_lvl), .rise(arm_rise), .fall(arm_fall));

   fgw_edge_sync #(.STAGES(SYNC_STAGES), .INVERT(1'b0)) u_done (
      .clk(clk), .rst(rst), .din(rd_done),
      .level(done_lvl), .rise(done_rise), .fall(done_fall));

   fgw_sequencer #(.RST_CYCLES(RST_CYCLES)) u_seq (
      .clk(clk), .rst(rst),
      .arm_rise(arm_rise), .done_rise(done_rise),
      .vs_rise(vs_rise), .vs_fall(vs_fall),
      .wrst_n(wrst_n), .cap_en(cap_en), .held(frame_held));

   assign we_n = ~(cap_en & href);

   AST_NO_WRITE_IN_RESET: assert property (@(posedge clk) disable iff (rst)
      !wrst_n |-> we_n); // R5
   AST_NO_WRITE_WHEN_HELD: assert property (@(posedge clk) disable iff (rst)
      frame_held |-> we_n); // R6
   AST_WRITE_IN_ACTIVE: assert property (@(posedge clk) disable iff (rst)
      !we_n |-> !vs_lvl); // R4
   AST_FLAG_AT_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
      $rose(frame_held) |-> vs_lvl); // R6
endmodule

// File: tb/sim_frame_grab_wctl.sv
module sim_frame_grab_wctl;
   localparam int CLK_PERIOD = 10;
   localparam int RST_CYC    = 3;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic vs = 1'b1, hr = 1'b0, arm = 1'b0, rdd = 1'b0;
   logic wrst0, we0, held0, wrst1, we1, held1;

   int checks = 0, errors = 0;
   int we_cnt0, wr_cnt0, wr_falls0, we_cnt1, wr_cnt1, wr_falls1;
   int href_cnt;
   logic wr_prev0 = 1'b1, wr_prev1 = 1'b1;

   always #(CLK_PERIOD/2) clk = ~clk;

   frame_grab_wctl #(.RST_CYCLES(RST_CYC)) u0 (
      .clk(clk), .rst(rst), .vsync(vs), .href(hr), .arm(arm), .rd_done(rdd),
      .wrst_n(wrst0), .we_n(we0), .frame_held(held0));

   frame_grab_wctl #(.RST_CYCLES(RST_CYC), .VS_INVERT(1'b1)) u1 (
      .clk(clk), .rst(rst), .vsync(~vs), .href(hr), .arm(arm), .rd_done(rdd),
      .wrst_n(wrst1), .we_n(we1), .frame_held(held1));

   always @(negedge clk) begin
      if (!we0) we_cnt0++;
      if (!wrst0) wr_cnt0++;
      if (wr_prev0 && !wrst0) wr_falls0++;
      wr_prev0 = wrst0;
      if (!we1) we_cnt1++;
      if (!wrst1) wr_cnt1++;
      if (wr_prev1 && !wrst1) wr_falls1++;
      wr_prev1 = wrst1;
      if (hr) href_cnt++;
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int exp_writes(input bit capture, input int pix);
      return capture ? pix : 0;
   endfunction

   function automatic int exp_pulse(input bit boundary_armed);
      return boundary_armed ? RST_CYC : 0;
   endfunction

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic pulse_arm();
      arm = 1'b1; step(2); arm = 1'b0;
   endtask

   task automatic pulse_done();
      rdd = 1'b1; step(2); rdd = 1'b0;
   endtask

   // One frame period: active part, then the boundary edge and blanking.
   task automatic period(input int lines, input int len, input bit cap,
                         input bit pul, input int arm_line, input string tag);
      we_cnt0 = 0; wr_cnt0 = 0; wr_falls0 = 0;
      we_cnt1 = 0; wr_cnt1 = 0; wr_falls1 = 0;
      href_cnt = 0;
      vs = 1'b0;
      step(8);
      for (int l = 0; l < lines; l++) begin
         hr = 1'b1; step(len);
         hr = 1'b0;
         if (l == arm_line) pulse_arm();
         step(3 + int'($urandom % 4));
      end
      step(6);
      vs = 1'b1;
      step(20);
      chk(we_cnt0 == exp_writes(cap, href_cnt), {tag, " writes"},
          we_cnt0, exp_writes(cap, href_cnt));
      chk(wr_cnt0 == exp_pulse(pul) && wr_falls0 == (pul ? 1 : 0),
          "R2 reset pulse width", wr_cnt0, exp_pulse(pul));
      chk(we_cnt1 == we_cnt0 && wr_cnt1 == wr_cnt0 && wr_falls1 == wr_falls0,
          "R3 inverted sync match", we_cnt1, we_cnt0);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin : stim
      void'($urandom(32'h0000_5a17));
      step(3);
      chk(wrst0 && we0 && !held0, "R1 reset state in reset", {wrst0, we0, held0}, 3'b110);
      rst = 1'b0;
      step(4);
      chk(wrst0 && we0 && !held0, "R1 idle after reset", {wrst0, we0, held0}, 3'b110);

      // Unarmed frame
      period(3, 10, 1'b0, 1'b0, -1, "R5 unarmed");
      // Arm in blanking; the frame it overlaps is not written
      pulse_arm(); step(4);
      period(2, 8, 1'b0, 1'b1, -1, "R5 arming frame");
      period(4, 12, 1'b1, 1'b0, -1, "R4 captured frame");
      @(negedge clk);
      chk(held0 == 1'b1, "R6 held after capture", held0, 1);
      step(1);
      // Held: further frames not written; arm ignored (R7)
      period(3, 9, 1'b0, 1'b0, 1, "R6 held frame");
      period(2, 7, 1'b0, 1'b0, -1, "R7 arm while held");
      @(negedge clk);
      chk(held0 == 1'b1, "R6 still held", held0, 1);
      step(1);
      pulse_done(); step(6);
      @(negedge clk);
      chk(held0 == 1'b0, "R6 released by read-done", held0, 0);
      step(1);
      period(3, 6, 1'b0, 1'b0, -1, "R7 no capture after release");

      // Arm mid-frame (R9)
      period(4, 10, 1'b0, 1'b1, 1, "R9 mid-frame arm");
      period(3, 11, 1'b1, 1'b0, -1, "R9 next frame captured");
      @(negedge clk);
      chk(held0 == 1'b1, "R9 held", held0, 1);
      step(1);

      // Arm and read-done on the same cycle (R8)
      arm = 1'b1; rdd = 1'b1; step(2); arm = 1'b0; rdd = 1'b0; step(6);
      @(negedge clk);
      chk(held0 == 1'b0, "R8 released", held0, 0);
      step(1);
      period(2, 9, 1'b0, 1'b0, -1, "R8 arm discarded");
      period(2, 9, 1'b0, 1'b0, -1, "R8 arm discarded again");

      // Random rounds
      for (int r = 0; r < 5; r++) begin
         int lines, len;
         lines = 2 + int'($urandom % 4);
         len   = 4 + int'($urandom % 12);
         pulse_arm(); step(4);
         period(lines, len, 1'b0, 1'b1, -1, "R5 random arming frame");
         period(lines, len, 1'b1, 1'b0, -1, "R4 random capture");
         @(negedge clk);
         chk(held0 == 1'b1, "R6 random held", held0, 1);
         step(1);
         pulse_done(); step(6);
         @(negedge clk);
         chk(held0 == 1'b0 && wrst0 && we0, "R6 random release", held0, 0);
         step(1);
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule